// File: doc/BRIEF.md
# Address-Key Configuration Unlock

This block sits beside the request decoder of a protected memory and watches the address of every enabled access. A configuration register is reached through a key instead of a dedicated register port. The key is five particular addresses presented on consecutive access strobes. The register holds three fields: the scrub-interval code, the busy-warning lead code and the error-correction bypass bit. The scrubber and the memory datapath consume these fields directly.

The five key accesses pass through to memory as ordinary accesses. The sixth strobe after a complete key is a configuration access, and it is redirected to the register. Its address selects the direction. It either loads the register from the write data or presents the register on the read-data path. While a sequence is in progress, the block raises a flag that tells the host it may ignore the busy indications. During the whole sequence the host holds the multiple-bit-error line high.

Top module: `cfg_unlock`

## Requirements
- R1: After reset, `scrub_rate` is 6, `warn_code` is 10, `edac_bypass` is 0, and `seq_active` and `cfg_access` are 0.
- R2: The key is 70000h, 7FF00h, 3A500h, 55A00h and 10500h. Each key address advances the match by one step when it arrives in order on an `acc_strobe` cycle with `host_err` high. `seq_active` is 1 from the cycle after the first matched key until the sequence completes or aborts.
- R3: Cycles with `acc_strobe` low never change the match state, whatever `acc_addr` holds.
- R4: A strobed address that does not equal the expected key address returns the matcher to idle. If that address equals 70000h, the matcher goes to step 1 instead.
- R5: A strobe with `host_err` low while the key is being matched returns the matcher to idle.
- R6: The sixth strobe is a configuration access when `acc_addr[18:10]` is 0 and `host_err` is high. When `acc_addr[9]` is 0, `cfg_access` is 1 in that cycle and `cfg_rd_en` is 0. From the next cycle the register holds `acc_wdata[8:0]`, with the scrub rate in bits 3:0, the warning code in bits 7:4 and the bypass in bit 8.
- R7: On a configuration access with `acc_addr[9]` equal to 1, `cfg_access` and `cfg_rd_en` are 1 in that cycle. `cfg_rdata` equals the register zero-extended, in the bit layout of R6, and the register is unchanged. `cfg_rdata` is 0 whenever `cfg_rd_en` is 0.
- R8: If the sixth strobe has a nonzero bit in `acc_addr[18:10]`, it is not a configuration access. The matcher returns to idle and the register is unchanged.
- R9: After a configuration access the matcher is idle. A further access at a configuration-style address has no effect until the full key is presented again.
- R10: `cfg_access` is 0 during the five key accesses and at every time the key has not been completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_strobe | input | 1 | One-cycle pulse marking the start of a new enabled access |
| acc_addr | input | ADDR_W | Access address |
| acc_wdata | input | DATA_W | Write data of the access |
| host_err | input | 1 | Multiple-bit-error line as driven by the host |
| seq_active | output | 1 | Key in progress; busy indications may be ignored |
| cfg_access | output | 1 | Current access targets the configuration register, not memory |
| cfg_rd_en | output | 1 | Configuration access is a read; drive `cfg_rdata` on the bus |
| cfg_rdata | output | DATA_W | Register read-back value |
| scrub_rate | output | RATE_W | Scrub-interval code |
| warn_code | output | WARN_W | Busy-warning lead code |
| edac_bypass | output | 1 | Bypass error correction when 1 |

## Verification
The hardest state to reach from the ports is the restart case. Here a key broken midway by the first key address must resume at step 1 and not at idle. The bench interrupts a partial key with 70000h and then supplies only the remaining four addresses and a write. The register update proves that the matcher resumed at step 1. A second hard case is a key spread out by idle cycles that carry garbage addresses with the strobe low. The bench then completes a read, which shows that only strobes advance the match.

// File: rtl/cfg_unlock.sv
module cfg_unlock #(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 32,
  parameter int RATE_W   = 4,
  parameter int WARN_W   = 4,
  parameter int DIR_BIT  = 9,
  parameter int RATE_RST = 6,
  parameter int WARN_RST = 10,
  parameter logic [ADDR_W-1:0] KEY0 = 'h70000,
  parameter logic [ADDR_W-1:0] KEY1 = 'h7FF00,
  parameter logic [ADDR_W-1:0] KEY2 = 'h3A500,
  parameter logic [ADDR_W-1:0] KEY3 = 'h55A00,
  parameter logic [ADDR_W-1:0] KEY4 = 'h10500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_strobe,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic              host_err,
  output logic              seq_active,
  output logic              cfg_access,
  output logic              cfg_rd_en,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic [RATE_W-1:0] scrub_rate,
  output logic [WARN_W-1:0] warn_code,
  output logic              edac_bypass
);
  localparam int CFG_W  = RATE_W + WARN_W + 1;
  localparam int STEP_W = 3;
  localparam logic [STEP_W-1:0] FINAL = STEP_W'(5);
  localparam logic [CFG_W-1:0] CFG_RST =
    {1'b0, WARN_W'(WARN_RST), RATE_W'(RATE_RST)};

  logic [STEP_W-1:0] step;
  logic [ADDR_W-1:0] key_now;
  logic [CFG_W-1:0]  cfg_q;

  always_comb begin
    case (step)
      STEP_W'(0): key_now = KEY0;
      STEP_W'(1): key_now = KEY1;
      STEP_W'(2): key_now = KEY2;
      STEP_W'(3): key_now = KEY3;
      default:    key_now = KEY4;
    endcase
  end

  wire at_final = (step == FINAL);
  wire key_hit  = host_err && (acc_addr == key_now);
  wire restart  = host_err && (acc_addr == KEY0);
  wire upper_ok = (acc_addr[ADDR_W-1:DIR_BIT+1] == '0);

  assign cfg_access  = acc_strobe && at_final && host_err && upper_ok;
  assign cfg_rd_en   = cfg_access && acc_addr[DIR_BIT];
  assign cfg_rdata   = cfg_rd_en ? DATA_W'(cfg_q) : '0;
  assign seq_active  = (step != '0);
  assign scrub_rate  = cfg_q[RATE_W-1:0];
  assign warn_code   = cfg_q[RATE_W +: WARN_W];
  assign edac_bypass = cfg_q[CFG_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      step <= '0;
    else if (acc_strobe) begin
      if (at_final)     step <= '0;
      else if (key_hit) step <= step + STEP_W'(1);
      else if (restart) step <= STEP_W'(1);
      else              step <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cfg_q <= CFG_RST;
    else if (cfg_access && !acc_addr[DIR_BIT])
      cfg_q <= acc_wdata[CFG_W-1:0];
  end
endmodule

module cfg_unlock_chk #(
  parameter int DATA_W = 32,
  parameter int RATE_W = 4,
  parameter int WARN_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_strobe,
  input logic [DATA_W-1:0] acc_wdata,
  input logic              seq_active,
  input logic              cfg_access,
  input logic              cfg_rd_en,
  input logic [DATA_W-1:0] cfg_rdata,
  input logic [RATE_W-1:0] scrub_rate,
  input logic [WARN_W-1:0] warn_code,
  input logic              edac_bypass
);
  localparam int CFG_W = RATE_W + WARN_W + 1;
  wire [CFG_W-1:0] fields = {edac_bypass, warn_code, scrub_rate};

  // R6
  wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_access && !cfg_rd_en |=> fields == $past(acc_wdata[CFG_W-1:0]));
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_access && !cfg_rd_en) |=> $stable(fields));
  // R7
  rd_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_en |-> cfg_rdata == DATA_W'(fields));
  // R10
  only_in_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_access |-> seq_active);
  // R3
  no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_strobe |=> $stable(seq_active));
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_access |=> !seq_active);
  // R7
  rd_needs_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_en |-> cfg_access);
endmodule

bind cfg_unlock cfg_unlock_chk #(.DATA_W(DATA_W), .RATE_W(RATE_W), .WARN_W(WARN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_strobe(acc_strobe), .acc_wdata(acc_wdata),
  .seq_active(seq_active), .cfg_access(cfg_access), .cfg_rd_en(cfg_rd_en),
  .cfg_rdata(cfg_rdata), .scrub_rate(scrub_rate), .warn_code(warn_code),
  .edac_bypass(edac_bypass)
);

// File: tb/tb_cfg_unlock.sv
module tb_cfg_unlock;
  localparam int CLK_PERIOD = 10;
  localparam logic [18:0] K0 = 19'h70000, K1 = 19'h7FF00, K2 = 19'h3A500,
                          K3 = 19'h55A00, K4 = 19'h10500;

  logic        clk = 1'b0, rst_n = 1'b0, acc_strobe = 1'b0, host_err = 1'b0;
  logic [18:0] acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic        seq_active, cfg_access, cfg_rd_en, edac_bypass;
  logic [31:0] cfg_rdata;
  logic [3:0]  scrub_rate, warn_code;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_unlock dut (
    .clk(clk), .rst_n(rst_n), .acc_strobe(acc_strobe), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .host_err(host_err), .seq_active(seq_active),
    .cfg_access(cfg_access), .cfg_rd_en(cfg_rd_en), .cfg_rdata(cfg_rdata),
    .scrub_rate(scrub_rate), .warn_code(warn_code), .edac_bypass(edac_bypass)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One strobed access; outputs of the same cycle are captured mid-cycle.
  task automatic acc(input logic [18:0] a, input logic [31:0] d, input logic e,
                     output logic ca, output logic rd, output logic [31:0] rdat);
    @(negedge clk);
    acc_addr = a; acc_wdata = d; host_err = e; acc_strobe = 1'b1;
    #(CLK_PERIOD/4);
    ca = cfg_access; rd = cfg_rd_en; rdat = cfg_rdata;
    @(negedge clk);
    acc_strobe = 1'b0; acc_addr = 19'h0ABCD;
  endtask

  task automatic chk_fields(input string req, input logic [8:0] exp);
    chk(req, {23'd0, edac_bypass, warn_code, scrub_rate}, {23'd0, exp});
  endtask

  task automatic send_key(input int upto);
    logic ca, rd; logic [31:0] rdat;
    logic [18:0] keys [5] = '{K0, K1, K2, K3, K4};
    for (int i = 0; i < upto; i++) begin
      acc(keys[i], 32'h0, 1'b1, ca, rd, rdat);
      chk("R10 key step no cfg", {31'd0, ca}, 32'd0);
    end
  endtask

  task automatic t_reset;
    chk_fields("R1 defaults", {1'b0, 4'd10, 4'd6});
    chk("R1 seq_active", {31'd0, seq_active}, 32'd0);
    chk("R1 cfg_access", {31'd0, cfg_access}, 32'd0);
  endtask

  task automatic t_write;
    logic ca, rd; logic [31:0] rdat;
    send_key(1);
    chk("R2 active after first key", {31'd0, seq_active}, 32'd1);
    send_key(0);
    acc(K1, 0, 1, ca, rd, rdat); acc(K2, 0, 1, ca, rd, rdat);
    acc(K3, 0, 1, ca, rd, rdat); acc(K4, 0, 1, ca, rd, rdat);
    chk("R2 active before final", {31'd0, seq_active}, 32'd1);
    acc(19'h000AB, 32'hFFFF_F1A5, 1, ca, rd, rdat);
    chk("R6 cfg_access on write", {31'd0, ca}, 32'd1);
    chk("R6 not read", {31'd0, rd}, 32'd0);
    chk_fields("R6 loaded", 9'h1A5);
    chk("R9 idle after config", {31'd0, seq_active}, 32'd0);
  endtask

  task automatic t_read;
    logic ca, rd; logic [31:0] rdat;
    send_key(5);
    acc(19'h00200, 32'h0000_0000, 1, ca, rd, rdat);
    chk("R7 cfg_access on read", {31'd0, ca}, 32'd1);
    chk("R7 rd_en", {31'd0, rd}, 32'd1);
    chk("R7 rdata", rdat, 32'h0000_01A5);
    chk_fields("R7 unchanged by read", 9'h1A5);
    chk("R7 rdata zero outside read", cfg_rdata, 32'd0);
  endtask

  task automatic t_wrong;
    logic ca, rd; logic [31:0] rdat;
    send_key(3);
    acc(19'h12345, 0, 1, ca, rd, rdat);
    chk("R4 mismatch to idle", {31'd0, seq_active}, 32'd0);
    acc(19'h00000, 32'h0, 1, ca, rd, rdat);
    chk("R10 no cfg when idle", {31'd0, ca}, 32'd0);
    chk_fields("R4 register kept", 9'h1A5);
  endtask

  task automatic t_restart;
    logic ca, rd; logic [31:0] rdat;
    send_key(2);
    acc(K0, 0, 1, ca, rd, rdat);
    chk("R4 restart at step 1", {31'd0, seq_active}, 32'd1);
    acc(K1, 0, 1, ca, rd, rdat); acc(K2, 0, 1, ca, rd, rdat);
    acc(K3, 0, 1, ca, rd, rdat); acc(K4, 0, 1, ca, rd, rdat);
    acc(19'h00011, 32'h0000_00C3, 1, ca, rd, rdat);
    chk("R4 restart completes", {31'd0, ca}, 32'd1);
    chk_fields("R6 second load", 9'h0C3);
  endtask

  task automatic t_nostrobe;
    logic ca, rd; logic [31:0] rdat;
    send_key(2);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); acc_addr = 19'h7FFFF - 19'(i);
    end
    chk("R3 held without strobe", {31'd0, seq_active}, 32'd1);
    acc(K2, 0, 1, ca, rd, rdat); acc(K3, 0, 1, ca, rd, rdat);
    acc(K4, 0, 1, ca, rd, rdat);
    acc(19'h002FF, 0, 1, ca, rd, rdat);
    chk("R3 read after gaps", rdat, 32'h0000_00C3);
  endtask

  task automatic t_errlow;
    logic ca, rd; logic [31:0] rdat;
    send_key(1);
    acc(K1, 0, 0, ca, rd, rdat);
    chk("R5 err low aborts", {31'd0, seq_active}, 32'd0);
  endtask

  task automatic t_upper;
    logic ca, rd; logic [31:0] rdat;
    send_key(5);
    acc(19'h00400, 32'h0000_0000, 1, ca, rd, rdat);
    chk("R8 no cfg with upper bit", {31'd0, ca}, 32'd0);
    chk("R8 idle", {31'd0, seq_active}, 32'd0);
    chk_fields("R8 unchanged", 9'h0C3);
  endtask

  task automatic t_after;
    logic ca, rd; logic [31:0] rdat;
    send_key(5);
    acc(19'h00000, 32'h0000_0055, 1, ca, rd, rdat);
    acc(19'h00000, 32'h0000_0111, 1, ca, rd, rdat);
    chk("R9 repeat ignored", {31'd0, ca}, 32'd0);
    chk_fields("R9 keeps first write", 9'h055);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_write;
    t_read;
    t_wrong;
    t_restart;
    t_nostrobe;
    t_errlow;
    t_upper;
    t_after;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule